// File: doc/BRIEF.md
# Thread-Group Admission Controller

This block guards the shared resources of a single compute unit. It decides whether a newly launched group of threads may become resident there. A launch request carries two values: how many threads the group has, and how many registers each of those threads needs. From these the block works out the group's demand. That demand is one residency slot, a number of warps equal to the thread count divided by the warp width and rounded up, the threads themselves, and the thread count times the per-thread register count. The block checks this demand against four pools in the same cycle.

If every pool can take the demand, the request is granted and the group receives a small slot handle. The handle indexes a table that records exactly what the group holds. When the group finishes, its handle is presented on the release port and the recorded amounts flow back into the pools. A release and a new request may arrive in the same cycle. The release is applied first, so a request can use capacity freed in that same cycle.

The block reports occupancy continuously as the number of resident warps. A scheduler can compare this against the warp capacity.

Top module: `blk_admit_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `gnt_valid` is 0 and `occ_warps` is 0, and every slot handle is free.
- R2: Each cycle with `req_valid` high produces `gnt_valid` high on the following cycle; a cycle without a request produces `gnt_valid` low on the following cycle.
- R3: A request for 0 threads or for more than 1024 threads is always refused (`gnt_ok` = 0), whatever the free capacity.
- R4: A granted group occupies ceil(threads / 32) warps, so 31 threads take 1 warp, 33 take 2 and 1024 take 32.
- R5: At most 32 groups are resident; a request arriving while 32 are resident is refused.
- R6: At most 64 warps are resident; a request whose warps would push the total above 64 is refused.
- R7: The register pool holds 65536 entries and a group consumes threads × per-thread registers; a request that would exceed the pool is refused, so one group of 1024 threads at 64 registers fills it.
- R8: A refused request changes no pool: `occ_warps` and all later decisions are as if it had not arrived.
- R9: A grant returns on `gnt_handle` the lowest-numbered free 5-bit slot handle.
- R10: A release naming a resident handle returns exactly the warps, threads, registers and slot recorded at grant; a release naming a non-resident handle has no effect.
- R11: A release and a request in the same cycle are both handled, with the release applied before the admission check.
- R12: `occ_warps` reports resident warps (0 to 64) and changes on the cycle after the grant or release that causes the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Launch request present this cycle |
| req_threads | input | 11 | Thread count of the requested group |
| req_regs | input | 8 | Registers needed per thread |
| rel_valid | input | 1 | Release present this cycle |
| rel_handle | input | 5 | Slot handle of the finishing group |
| gnt_valid | output | 1 | Decision for the previous cycle's request is present |
| gnt_ok | output | 1 | 1 = granted, 0 = refused |
| gnt_handle | output | 5 | Slot handle of the granted group (0 when refused) |
| occ_warps | output | 7 | Resident warp count |

## Verification
The bench builds the controller with its default sizes: 32 slots, 64 warps of 32 threads, a 1024-thread cap per group and 65536 registers. With these values each limit is reached within a few requests. One 1024×64 group fills the register file. Two 1024-thread groups fill the warp slots while leaving registers free. Thirty-two single-warp groups exhaust the slot table while warps stand at half capacity. Every refusal can therefore be traced to one pool, and same-cycle release-then-admit, non-resident releases and the warp rounding boundaries are driven directly.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
  localparam int unsigned DEF_MAX_GROUPS        = 32;
  localparam int unsigned DEF_MAX_WARPS         = 64;
  localparam int unsigned DEF_WARP_SIZE         = 32;
  localparam int unsigned DEF_MAX_GROUP_THREADS = 1024;
  localparam int unsigned DEF_REG_POOL          = 65536;
  localparam int unsigned DEF_REG_W             = 8;

  // Width of a wide scratch sum used for all capacity comparisons
  localparam int unsigned CMP_W = 32;
endpackage

// File: rtl/blk_demand.sv
module blk_demand #(
  parameter int unsigned WARP_SIZE         = 32,
  parameter int unsigned MAX_GROUP_THREADS = 1024,
  parameter int unsigned TW                = 11,
  parameter int unsigned RW                = 8,
  parameter int unsigned WW                = 7,
  localparam int unsigned DRW              = TW + RW,
  localparam int unsigned SH               = $clog2(WARP_SIZE)
) (
  input  logic [TW-1:0]  threads,
  input  logic [RW-1:0]  regs,
  output logic           legal,
  output logic [WW-1:0]  warps,
  output logic [DRW-1:0] regs_total
);
  logic [TW:0] rounded;

  always_comb begin
    legal      = (threads != '0) && ({1'b0, threads} <= (TW+1)'(MAX_GROUP_THREADS));
    rounded    = {1'b0, threads} + (TW+1)'(WARP_SIZE - 1);
    warps      = WW'(rounded >> SH);
    regs_total = DRW'(threads) * DRW'(regs);
  end
endmodule

// File: rtl/blk_slot_table.sv
module blk_slot_table #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned EW    = 35,
  localparam int unsigned HW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [HW-1:0] wr_idx,
  input  logic [EW-1:0] wr_data,
  input  logic          rel_en,
  input  logic [HW-1:0] rel_idx,
  output logic [EW-1:0] rd_data,
  output logic          rel_hit,
  output logic          free_any,
  output logic [HW-1:0] free_idx
);
  // Per-handle record, no reset so it maps to distributed RAM
  logic [EW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] live;
  logic [DEPTH-1:0] live_after;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data    = mem[rel_idx];
  assign rel_hit    = rel_en && live[rel_idx];
  assign live_after = live & ~(rel_hit ? (DEPTH'(1) << rel_idx) : '0);

  // Lowest free index wins
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!live_after[i]) begin
        free_any = 1'b1;
        free_idx = HW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else     live <= live_after | (wr_en ? (DEPTH'(1) << wr_idx) : '0);
  end

  // R9
  no_double_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !live_after[wr_idx]);
endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl
  import blk_admit_pkg::*;
#(
  parameter int unsigned MAX_GROUPS        = DEF_MAX_GROUPS,
  parameter int unsigned MAX_WARPS         = DEF_MAX_WARPS,
  parameter int unsigned WARP_SIZE         = DEF_WARP_SIZE,
  parameter int unsigned MAX_GROUP_THREADS = DEF_MAX_GROUP_THREADS,
  parameter int unsigned REG_POOL          = DEF_REG_POOL,
  parameter int unsigned REG_W             = DEF_REG_W,
  localparam int unsigned HW          = $clog2(MAX_GROUPS),
  localparam int unsigned TW          = $clog2(MAX_GROUP_THREADS + 1),
  localparam int unsigned WW          = $clog2(MAX_WARPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [TW-1:0]    req_threads,
  input  logic [REG_W-1:0] req_regs,
  input  logic             rel_valid,
  input  logic [HW-1:0]    rel_handle,
  output logic             gnt_valid,
  output logic             gnt_ok,
  output logic [HW-1:0]    gnt_handle,
  output logic [WW-1:0]    occ_warps
);
  localparam int unsigned GW          = $clog2(MAX_GROUPS + 1);
  localparam int unsigned MAX_THREADS = MAX_WARPS * WARP_SIZE;
  localparam int unsigned THW         = $clog2(MAX_THREADS + 1);
  localparam int unsigned RPW         = $clog2(REG_POOL + 1);
  localparam int unsigned DRW         = TW + REG_W;
  localparam int unsigned EW          = WW + TW + RPW;
  localparam int unsigned SW          = CMP_W;

  logic [GW-1:0]  used_groups, av_groups;
  logic [WW-1:0]  used_warps,  av_warps;
  logic [THW-1:0] used_threads, av_threads;
  logic [RPW-1:0] used_regs,   av_regs;

  logic           legal;
  logic [WW-1:0]  d_warps;
  logic [DRW-1:0] d_regs;
  logic [EW-1:0]  rec, wr_rec;
  logic           rel_hit, free_any, fit, grant;
  logic [HW-1:0]  free_idx;
  logic [WW-1:0]  rec_warps;
  logic [TW-1:0]  rec_threads;
  logic [RPW-1:0] rec_regs;

  blk_demand #(
    .WARP_SIZE(WARP_SIZE), .MAX_GROUP_THREADS(MAX_GROUP_THREADS),
    .TW(TW), .RW(REG_W), .WW(WW)
  ) u_demand (
    .threads(req_threads), .regs(req_regs),
    .legal(legal), .warps(d_warps), .regs_total(d_regs)
  );

  assign wr_rec = {d_warps, req_threads, RPW'(d_regs)};

  blk_slot_table #(.DEPTH(MAX_GROUPS), .EW(EW)) u_slots (
    .clk(clk), .rst(rst),
    .wr_en(grant), .wr_idx(free_idx), .wr_data(wr_rec),
    .rel_en(rel_valid), .rel_idx(rel_handle),
    .rd_data(rec), .rel_hit(rel_hit),
    .free_any(free_any), .free_idx(free_idx)
  );

  assign rec_warps   = rec[EW-1 -: WW];
  assign rec_threads = rec[TW+RPW-1 -: TW];
  assign rec_regs    = rec[RPW-1:0];

  // Release first, then admission on what remains
  always_comb begin
    av_groups  = used_groups  - GW'(rel_hit);
    av_warps   = used_warps   - (rel_hit ? rec_warps : '0);
    av_threads = used_threads - (rel_hit ? THW'(rec_threads) : '0);
    av_regs    = used_regs    - (rel_hit ? rec_regs : '0);
    fit = legal && free_any
       && (SW'(av_groups) < SW'(MAX_GROUPS))
       && (SW'(av_warps) + SW'(d_warps) <= SW'(MAX_WARPS))
       && (SW'(av_threads) + SW'(req_threads) <= SW'(MAX_THREADS))
       && (SW'(av_regs) + SW'(d_regs) <= SW'(REG_POOL));
    grant = req_valid && fit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_groups  <= '0;
      used_warps   <= '0;
      used_threads <= '0;
      used_regs    <= '0;
      gnt_valid    <= 1'b0;
      gnt_ok       <= 1'b0;
      gnt_handle   <= '0;
    end else begin
      used_groups  <= av_groups  + GW'(grant);
      used_warps   <= av_warps   + (grant ? d_warps : '0);
      used_threads <= av_threads + (grant ? THW'(req_threads) : '0);
      used_regs    <= av_regs    + (grant ? RPW'(d_regs) : '0);
      gnt_valid    <= req_valid;
      gnt_ok       <= grant;
      gnt_handle   <= grant ? free_idx : '0;
    end
  end

  assign occ_warps = used_warps;

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> gnt_valid);
  // R3
  illegal_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !legal) |=> !gnt_ok);
  // R5
  group_cap_chk: assert property (@(posedge clk) disable iff (rst)
    SW'(used_groups) <= SW'(MAX_GROUPS));
  // R6
  warp_cap_chk: assert property (@(posedge clk) disable iff (rst)
    SW'(occ_warps) <= SW'(MAX_WARPS));
  // R7
  reg_cap_chk: assert property (@(posedge clk) disable iff (rst)
    SW'(used_regs) <= SW'(REG_POOL));
  // R8
  refuse_keeps_occ_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && !gnt_ok && !$past(rel_valid)) |-> $stable(occ_warps));
endmodule

// File: tb/blk_admit_ctrl_test.sv
module blk_admit_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [10:0] req_threads;
  logic [7:0]  req_regs;
  logic        rel_valid;
  logic [4:0]  rel_handle;
  logic        gnt_valid, gnt_ok;
  logic [4:0]  gnt_handle;
  logic [6:0]  occ_warps;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_admit_ctrl uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_threads(req_threads), .req_regs(req_regs),
    .rel_valid(rel_valid), .rel_handle(rel_handle),
    .gnt_valid(gnt_valid), .gnt_ok(gnt_ok), .gnt_handle(gnt_handle),
    .occ_warps(occ_warps)
  );

  // {rel_v, rel_h[5], req_v, threads[11], regs[8], exp_ok, exp_h[5], exp_occ[7]}
  localparam logic [38:0] VECS [NV] = '{
    {1'b0, 5'd0, 1'b1, 11'd100,  8'd16, 1'b1, 5'd0, 7'd4 },  // R4 R9 R12
    {1'b0, 5'd0, 1'b1, 11'd0,    8'd4,  1'b0, 5'd0, 7'd4 },  // R3
    {1'b0, 5'd0, 1'b1, 11'd1025, 8'd1,  1'b0, 5'd0, 7'd4 },  // R3
    {1'b0, 5'd0, 1'b1, 11'd1024, 8'd64, 1'b0, 5'd0, 7'd4 },  // R7 R8
    {1'b1, 5'd0, 1'b0, 11'd0,    8'd0,  1'b0, 5'd0, 7'd0 },  // R10
    {1'b0, 5'd0, 1'b1, 11'd1024, 8'd64, 1'b1, 5'd0, 7'd32},  // R7 R3 (1024 legal)
    {1'b0, 5'd0, 1'b1, 11'd32,   8'd1,  1'b0, 5'd0, 7'd32},  // R7
    {1'b1, 5'd0, 1'b1, 11'd1024, 8'd64, 1'b1, 5'd0, 7'd32},  // R11
    {1'b1, 5'd5, 1'b0, 11'd0,    8'd0,  1'b0, 5'd0, 7'd32},  // R10 non-resident
    {1'b1, 5'd0, 1'b0, 11'd0,    8'd0,  1'b0, 5'd0, 7'd0 },  // R10
    {1'b0, 5'd0, 1'b1, 11'd1024, 8'd32, 1'b1, 5'd0, 7'd32},  // R4
    {1'b0, 5'd0, 1'b1, 11'd1024, 8'd32, 1'b1, 5'd1, 7'd64},  // R9
    {1'b0, 5'd0, 1'b1, 11'd1,    8'd1,  1'b0, 5'd0, 7'd64},  // R6 R7
    {1'b1, 5'd0, 1'b0, 11'd0,    8'd0,  1'b0, 5'd0, 7'd32},  // R12
    {1'b0, 5'd0, 1'b1, 11'd33,   8'd0,  1'b1, 5'd0, 7'd34},  // R4 R9
    {1'b1, 5'd1, 1'b0, 11'd0,    8'd0,  1'b0, 5'd0, 7'd2 },  // R10
    {1'b1, 5'd0, 1'b0, 11'd0,    8'd0,  1'b0, 5'd0, 7'd0 },  // R10
    {1'b0, 5'd0, 1'b1, 11'd1024, 8'd1,  1'b1, 5'd0, 7'd32},  // R4
    {1'b0, 5'd0, 1'b1, 11'd1024, 8'd1,  1'b1, 5'd1, 7'd64},  // R6
    {1'b0, 5'd0, 1'b1, 11'd32,   8'd1,  1'b0, 5'd0, 7'd64},  // R6 warps alone
    {1'b1, 5'd0, 1'b0, 11'd0,    8'd0,  1'b0, 5'd0, 7'd32},  // R10
    {1'b1, 5'd1, 1'b0, 11'd0,    8'd0,  1'b0, 5'd0, 7'd0 },  // R10
    {1'b0, 5'd0, 1'b1, 11'd31,   8'd2,  1'b1, 5'd0, 7'd1 },  // R4 rounding
    {1'b1, 5'd0, 1'b1, 11'd64,   8'd2,  1'b1, 5'd0, 7'd2 },  // R11
    {1'b1, 5'd0, 1'b0, 11'd0,    8'd0,  1'b0, 5'd0, 7'd0 }   // R10
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_threads = '0; req_regs = '0;
    rel_valid = 1'b0; rel_handle = '0;
  endtask

  // Drive at negedge, let one edge pass, sample at the next negedge
  task automatic step(input bit rv, input logic [4:0] rh, input bit qv,
                      input logic [10:0] th, input logic [7:0] rg);
    rel_valid = rv; rel_handle = rh; req_valid = qv; req_threads = th; req_regs = rg;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic expect_out(input bit qv, input bit eok, input logic [4:0] eh,
                            input logic [6:0] eocc, input string tag);
    check(gnt_valid == qv, {tag, " R2 gnt_valid"}, int'(gnt_valid), int'(qv));
    if (qv) begin
      check(gnt_ok == eok, {tag, " gnt_ok"}, int'(gnt_ok), int'(eok));
      if (eok) check(gnt_handle == eh, {tag, " R9 gnt_handle"}, int'(gnt_handle), int'(eh));
    end
    check(occ_warps == eocc, {tag, " R12 occ_warps"}, int'(occ_warps), int'(eocc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held at zero in reset
    check(gnt_valid == 1'b0, "R1 gnt_valid in reset", int'(gnt_valid), 0);
    check(occ_warps == 7'd0, "R1 occ_warps in reset", int'(occ_warps), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(gnt_valid == 1'b0, "R1 gnt_valid after reset", int'(gnt_valid), 0);
    check(occ_warps == 7'd0, "R1 occ_warps after reset", int'(occ_warps), 0);

    // Table walk (R1 first grant gets handle 0)
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VECS[i];
      step(v[38], v[37:33], v[32], v[31:21], v[20:13]);
      expect_out(v[32], v[12], v[11:7], v[6:0], $sformatf("row %0d", i));
    end

    // R5: fill all 32 slots with one-warp groups
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 5'd0, 1'b1, 11'd32, 8'd1);
      expect_out(1'b1, 1'b1, 5'(i), 7'(i + 1), $sformatf("R5 fill %0d", i));
    end
    step(1'b0, 5'd0, 1'b1, 11'd32, 8'd1);
    expect_out(1'b1, 1'b0, 5'd0, 7'd32, "R5 33rd group refused");

    // R9: freed middle slot is the lowest free one
    step(1'b1, 5'd7, 1'b0, 11'd0, 8'd0);
    expect_out(1'b0, 1'b0, 5'd0, 7'd31, "R10 release slot 7");
    step(1'b0, 5'd0, 1'b1, 11'd32, 8'd1);
    expect_out(1'b1, 1'b1, 5'd7, 7'd32, "R9 reuse slot 7");

    // R10: drain all
    for (int i = 0; i < 32; i++) begin
      step(1'b1, 5'(i), 1'b0, 11'd0, 8'd0);
      expect_out(1'b0, 1'b0, 5'd0, 7'(31 - i), $sformatf("R10 drain %0d", i));
    end

    // R8: after everything, full register pool is available again
    step(1'b0, 5'd0, 1'b1, 11'd1024, 8'd64);
    expect_out(1'b1, 1'b1, 5'd0, 7'd32, "R8 pools restored");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule